// File: doc/BRIEF.md
# Clock Output Power-Mode Controller

This block sits at the end of a clock generator and decides what reaches the differential output pair. It takes a free-running source clock and two active-low control pins, one for power-down and one for stop. From these it selects one of three operating states. In the running state the pair carries the source clock and its inverse. In the halted state both legs are held high, and the source keeps running underneath. In the off state both legs are held low. The state is reported on a 2-bit code.

The block also holds the multiplier-select bits and mode-select bits that configure the upstream generator. It copies them from their pins only while it is in the off state. In every other state the registered copies stay frozen, so the generator never sees a configuration change while its output is live.

Both control pins pass through a synchronizer on the source clock. The synchronized values then feed a state register. A pin change therefore takes effect on the third rising edge after it is sampled. State transitions are allowed to glitch. Reset places the block in the off state. After reset is released, the block moves straight to whatever state the pins select, with no start sequence.

Top module: `clk_out_power_ctrl`

## Requirements
- R1: In the running state (power-down pin high, stop pin high), `clkOutP` follows `clkSrc` and `clkOutN` follows its inverse.
- R2: In the halted state (power-down pin high, stop pin low), `clkOutP` and `clkOutN` are both held at 1.
- R3: In the off state (power-down pin low), `clkOutP` and `clkOutN` are both 0, whatever the value of the stop pin.
- R4: `multCfg` and `modeCfg` take the values of `multSel` and `modeSel` on each rising edge at which the state held before that edge is off.
- R5: On any rising edge at which the state held before that edge is running or halted, `multCfg` and `modeCfg` keep their values.
- R6: `pwrState` encodes the states as running = 0, halted = 1 and off = 2, and never shows 3. A change on either control pin appears on `pwrState`, and on the outputs, at the third rising edge after the pins are sampled.
- R7: While `rstN` is low, `pwrState` is 2, both output legs are 0, and the configuration copies are 0. After `rstN` rises, the block reaches the state selected by the pins at the third rising edge, with no fixed sequence in between.
- R8: A return from halted to running restarts the output toggling in the first clock half-period after `pwrState` changes, with no extra restart delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkSrc | input | 1 | Free-running source clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrDnN | input | 1 | Active-low power-down control |
| stopN | input | 1 | Active-low output stop control |
| multSel | input | MULT_W (2) | Multiplier-select configuration pins |
| modeSel | input | MODE_W (3) | Mode-select configuration pins |
| clkOutP | output | 1 | True leg of the gated clock pair |
| clkOutN | output | 1 | Complement leg of the gated clock pair |
| multCfg | output | MULT_W (2) | Registered multiplier-select bits |
| modeCfg | output | MODE_W (3) | Registered mode-select bits |
| pwrState | output | 2 | Operating state code |

## Verification
A wrong state register shows up at the ports within half a clock period. In that time the output pair shows the wrong relationship: equal legs where they should be complementary, high where they should be low, or no toggling at all. The state code is compared on every edge, so a change one edge early or one edge late is reported on the edge where it happens. A configuration latch that opens outside the off state is caught on the first edge after a pin change made while the output is running or halted. The bench deliberately changes the configuration pins in those states to provoke this.

// File: rtl/cpm_pkg.sv
`timescale 1ns/1ps
package cpm_pkg;

  // State codes seen on the pwrState port
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_OFF  = 2'd2
  } pwrState_e;

  // Strobes from the mode control to the output datapath
  typedef struct packed {
    logic passClk;   // forward the source clock to the pair
    logic holdHigh;  // park both legs high
    logic loadCfg;   // configuration latch open
  } gateCtl_t;

  function automatic pwrState_e decodePins(input logic pdnN, input logic stpN);
    if (!pdnN)      return ST_OFF;
    else if (!stpN) return ST_HALT;
    else            return ST_RUN;
  endfunction

endpackage

// File: rtl/cpm_sync.sv
`timescale 1ns/1ps
module cpm_sync #(
  parameter int           WIDTH   = 2,
  parameter int           STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= RST_VAL;
        else       chain[s] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= RST_VAL;
        else       chain[s] <= chain[s-1];
      end
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/cpm_mode_fsm.sv
`timescale 1ns/1ps
module cpm_mode_fsm
  import cpm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pdnSync,
  input  logic      stopSync,
  output pwrState_e stateQ,
  output gateCtl_t  ctl
);

  pwrState_e stateNext;

  always_comb begin
    stateNext = decodePins(pdnSync, stopSync);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_OFF;
    else       stateQ <= stateNext;
  end

  always_comb begin
    ctl          = '0;
    unique case (stateQ)
      ST_RUN:  ctl.passClk  = 1'b1;
      ST_HALT: ctl.holdHigh = 1'b1;
      ST_OFF:  ctl.loadCfg  = 1'b1;
      default: ctl          = '0;
    endcase
  end

  // R3: power-down low lands in off one edge later, stop ignored
  p_off_entry_r3: assert property (@(posedge clk) disable iff (!rstN)
    !pdnSync |=> stateQ == ST_OFF);

  // R2: stop low with power up lands in halted
  p_halt_entry_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pdnSync && !stopSync) |=> stateQ == ST_HALT);

  // R1: both controls high lands in running
  p_run_entry_r1: assert property (@(posedge clk) disable iff (!rstN)
    (pdnSync && stopSync) |=> stateQ == ST_RUN);

  // R6: legal code, exactly one strobe active
  p_state_legal_r6: assert property (@(posedge clk) disable iff (!rstN)
    stateQ != 2'd3 && $countones(ctl) == 1);

endmodule

// File: rtl/cpm_out_path.sv
`timescale 1ns/1ps
module cpm_out_path
  import cpm_pkg::*;
#(
  parameter int MULT_W = 2,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateCtl_t          ctl,
  input  logic [MULT_W-1:0] multPin,
  input  logic [MODE_W-1:0] modePin,
  output logic              outTrue,
  output logic              outComp,
  output logic [MULT_W-1:0] multQ,
  output logic [MODE_W-1:0] modeQ
);

  localparam int CFG_W = MULT_W + MODE_W;

  logic [CFG_W-1:0] cfgQ;
  logic [CFG_W-1:0] cfgPins;

  assign cfgPins = {multPin, modePin};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cfgQ <= '0;
    else if (ctl.loadCfg) cfgQ <= cfgPins;
  end

  assign multQ = cfgQ[CFG_W-1:MODE_W];
  assign modeQ = cfgQ[MODE_W-1:0];

  // Output gating: transitions between states may glitch
  always_comb begin
    if (ctl.passClk) begin
      outTrue = clk;
      outComp = ~clk;
    end else begin
      outTrue = ctl.holdHigh;
      outComp = ctl.holdHigh;
    end
  end

  // R5: latch closed outside off
  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadCfg |=> $stable(cfgQ));

  // R4: latch captures pins while off
  p_cfg_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadCfg |=> cfgQ == $past(cfgPins));

  // R1: running pair is complementary
  p_run_comp_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctl.passClk |-> outTrue != outComp);

  // R2: halted pair parked high
  p_halt_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.holdHigh |-> (outTrue && outComp));

  // R3: off pair parked low
  p_off_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadCfg |-> (!outTrue && !outComp));

endmodule

// File: rtl/clk_out_power_ctrl.sv
`timescale 1ns/1ps
module clk_out_power_ctrl
  import cpm_pkg::*;
#(
  parameter int MULT_W      = 2,
  parameter int MODE_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clkSrc,
  input  logic              rstN,
  input  logic              pwrDnN,
  input  logic              stopN,
  input  logic [MULT_W-1:0] multSel,
  input  logic [MODE_W-1:0] modeSel,
  output logic              clkOutP,
  output logic              clkOutN,
  output logic [MULT_W-1:0] multCfg,
  output logic [MODE_W-1:0] modeCfg,
  output logic [1:0]        pwrState
);

  localparam int CTRL_W = 2;

  logic [CTRL_W-1:0] ctrlSync;
  pwrState_e         stateQ;
  gateCtl_t          gateCtl;

  // Reset value 0 decodes as off, matching the state register reset
  cpm_sync #(
    .WIDTH   (CTRL_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ('0)
  ) ctrlSync_i (
    .clk     (clkSrc),
    .rstN    (rstN),
    .asyncIn ({pwrDnN, stopN}),
    .syncOut (ctrlSync)
  );

  cpm_mode_fsm modeFsm_i (
    .clk      (clkSrc),
    .rstN     (rstN),
    .pdnSync  (ctrlSync[1]),
    .stopSync (ctrlSync[0]),
    .stateQ   (stateQ),
    .ctl      (gateCtl)
  );

  cpm_out_path #(
    .MULT_W (MULT_W),
    .MODE_W (MODE_W)
  ) outPath_i (
    .clk     (clkSrc),
    .rstN    (rstN),
    .ctl     (gateCtl),
    .multPin (multSel),
    .modePin (modeSel),
    .outTrue (clkOutP),
    .outComp (clkOutN),
    .multQ   (multCfg),
    .modeQ   (modeCfg)
  );

  assign pwrState = stateQ;

endmodule

// File: tb/clk_out_power_ctrl_tb_top.sv
`timescale 1ns/1ps
module clk_out_power_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       pwrDnN, stopN;
  logic [1:0] multSel;
  logic [2:0] modeSel;
  logic       clkOutP, clkOutN;
  logic [1:0] multCfg;
  logic [2:0] modeCfg;
  logic [1:0] pwrState;

  always #2.5 clk = ~clk;

  clk_out_power_ctrl dut_i (
    .clkSrc (clk), .rstN (rstN), .pwrDnN (pwrDnN), .stopN (stopN),
    .multSel (multSel), .modeSel (modeSel),
    .clkOutP (clkOutP), .clkOutN (clkOutN),
    .multCfg (multCfg), .modeCfg (modeCfg), .pwrState (pwrState)
  );

  int  total = 0;
  int  bad   = 0;
  bit  finished = 0;

  // Reference model: pin samples delayed through a queue
  int pipeQ[$];
  int mState, mMult, mMode;

  function automatic int pinCode(logic p, logic s);
    if (!p) return 2;
    if (!s) return 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipeQ  = {2, 2};
      mState = 2;
      mMult  = 0;
      mMode  = 0;
    end else begin
      if (mState == 2) begin
        mMult = multSel;
        mMode = modeSel;
      end
      pipeQ.push_back(pinCode(pwrDnN, stopN));
      mState = pipeQ.pop_front();
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Continuous comparison on both clock phases
  task automatic cmpAll();
    int expP, expN;
    string tag;
    case (mState)
      0: begin expP = clk;  expN = !clk; tag = "R1"; end
      1: begin expP = 1;    expN = 1;    tag = "R2"; end
      default: begin expP = 0; expN = 0; tag = "R3"; end
    endcase
    chk({tag, " clkOutP"}, clkOutP, expP);
    chk({tag, " clkOutN"}, clkOutN, expN);
    chk("R6 pwrState", pwrState, mState);
    chk("R4/R5 multCfg", multCfg, mMult);
    chk("R4/R5 modeCfg", modeCfg, mMode);
  endtask

  always begin
    @(posedge clk); #1 cmpAll();
    @(negedge clk); #1 cmpAll();
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; pwrDnN = 1'b1; stopN = 1'b1; multSel = 2'd1; modeSel = 3'd5;
    cyc(3);
    // R7: reset state
    chk("R7 state in reset", pwrState, 2);
    chk("R7 clkOutP in reset", clkOutP, 0);
    chk("R7 multCfg in reset", multCfg, 0);
    rstN = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R7 still off after 2 edges", pwrState, 2);
    @(posedge clk); #1;
    chk("R7 running at third edge", pwrState, 0);
    chk("R4 mult captured while off", multCfg, 1);
    chk("R4 mode captured while off", modeCfg, 5);

    // R5: pins changed while running are ignored
    @(negedge clk); multSel = 2'd2; modeSel = 3'd3;
    cyc(5);
    chk("R5 mult held running", multCfg, 1);
    chk("R5 mode held running", modeCfg, 5);

    // R6: exact latency of stop
    @(negedge clk); stopN = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R6 no change at edge 2", pwrState, 0);
    @(posedge clk); #1;
    chk("R6 halted at edge 3", pwrState, 1);
    chk("R2 halt P high", clkOutP, 1);
    chk("R2 halt N high", clkOutN, 1);
    @(negedge clk); #1;
    chk("R2 halt P high low phase", clkOutP, 1);
    modeSel = 3'd7;
    cyc(4);
    chk("R5 mode held halted", modeCfg, 5);

    // R8: restart from halted
    @(negedge clk); stopN = 1'b1;
    @(posedge clk); @(posedge clk); @(posedge clk); #1;
    chk("R8 running", pwrState, 0);
    chk("R8 P high phase", clkOutP, 1);
    chk("R8 N high phase", clkOutN, 0);
    @(negedge clk); #1;
    chk("R8 P low phase", clkOutP, 0);
    chk("R8 N low phase", clkOutN, 1);

    // R3: off ignores stop
    @(negedge clk); pwrDnN = 1'b0; multSel = 2'd3; modeSel = 3'd2;
    cyc(4);
    chk("R3 off", pwrState, 2);
    stopN = 1'b0; cyc(2);
    chk("R3 P low stop toggled", clkOutP, 0);
    stopN = 1'b1; cyc(4);
    chk("R3 N low stop toggled", clkOutN, 0);
    chk("R3 still off", pwrState, 2);
    chk("R4 mult loaded off", multCfg, 3);
    chk("R4 mode loaded off", modeCfg, 2);

    // Off directly to halted
    stopN = 1'b0; pwrDnN = 1'b1; cyc(4);
    chk("R2 off to halted", pwrState, 1);

    // Pseudo-random walk, compared every half period
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int k = 0; k < 600; k++) begin
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (lfsr[3:0] == 4'h0) pwrDnN = lfsr[4];
        if (lfsr[7:5] == 3'h1) stopN = lfsr[8];
        multSel = lfsr[10:9];
        modeSel = lfsr[13:11];
      end
    end

    // R7: asynchronous reset mid-run
    @(negedge clk); pwrDnN = 1'b1; stopN = 1'b1; cyc(4);
    rstN = 1'b0; #0.5;
    chk("R7 async reset state", pwrState, 2);
    chk("R7 async reset P", clkOutP, 0);
    chk("R7 async reset N", clkOutN, 0);
    cyc(2);
    rstN = 1'b1; cyc(5);
    chk("R7 recover running", pwrState, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule